// File: doc/BRIEF.md
# Masked Register Test Sequencer

This block is a hardware engine that replays a structured test image against the register space of a device under test. The image sits in a word-addressed memory that the engine reads through a synchronous port with one cycle of latency. It has two parts. The stimulus part is applied as masked read-modify-write accesses. The checking part is applied as masked reads compared against expected words. The engine drives the device through a simple register-bus master port. Every access is held until the device answers with ready.

Each image part begins with a header. The header holds a block count, then one pointer per block, then one pointer that marks where the last block ends. Each block begins with a sequence count and then one pointer per sequence. A sequence is laid out in this order: a device register start address, then L expected or stimulus values, then L masks. The engine does not store L. It derives L from the distance to the next sequence pointer, or to the end of the block. The engine processes stimulus block 0, then checking block 0, then stimulus block 1, and so on. The block count is taken from the stimulus header.

States: `S_IDLE` waits for `start`. `S_HDR_RD`/`S_HDR_LD` fetch the block count. `S_BLK_RD`/`S_BLK_LD` and `S_BEND_RD`/`S_BEND_LD` fetch a block's start and end. `S_NSEQ_RD`/`S_NSEQ_LD` fetch its sequence count. `S_SEQ_RD`/`S_SEQ_LD` and `S_SEND_RD`/`S_SEND_LD` fetch a sequence's start and end. `S_REG_RD`/`S_REG_LD` fetch the register address and derive the length. `S_VAL_RD`/`S_VAL_LD` and `S_MSK_RD`/`S_MSK_LD` fetch one value/mask pair. `S_BUS_RD` reads the register. `S_BUS_WR` writes the merged word, for stimulus only. `S_STEP_WORD`, `S_STEP_SEQ` and `S_STEP_BLK` advance the word, sequence and block/phase indices.

The transitions are as follows. A zero block count goes from `S_HDR_LD` to `S_IDLE`. A zero sequence count goes from `S_NSEQ_LD` to `S_STEP_BLK`. A zero length goes from `S_REG_LD` to `S_STEP_SEQ`. `S_BUS_RD` goes to `S_BUS_WR` in the stimulus phase and to `S_STEP_WORD` in the checking phase. `S_STEP_BLK` leaves a checking phase on the last block and returns to `S_IDLE`.

Top module: `imgseq_engine`

## Requirements
- R1: A `start` pulse in `S_IDLE` begins a run. `busy` is high from the next cycle until the run ends. The word at image address IN_BASE (stimulus header word 0) gives the block count N. If N = 0, the run ends with no register access.
- R2: For each block index k < N, the stimulus block k is processed in full before the checking block k. Both are processed before the stimulus block k+1. The checking image header is at address OUT_BASE.
- R3: A block header at address B holds the sequence count M at B, and sequence pointers at B+1..B+M. Header entry k+1 gives the end of block k. A sequence at address P that ends at address E holds L = (E-P-1)/2 words. The register start address is at P. The values are at P+1..P+L and the masks at P+L+1..P+2L. Word i applies to register (start + i). A block with M = 0 does nothing.
- R4: For each stimulus word, the register is read first. Then the value (~mask & current) | (mask & value) is written to the same address.
- R5: For each checking word, the register is read and compared as mask & (read ^ expected). Bits with a mask of 0 are ignored. The checking phase never writes.
- R6: On the first checking word with a non-zero mismatch, `fail` is set, and `fail_addr` and `fail_vec` capture that register address and mismatch vector. Later mismatches do not change them. The run still completes. A new accepted `start` clears all three.
- R7: A bus request (`bus_req`) with its address, direction (`bus_we` = 1 for a write) and write data stays stable until a cycle with `bus_ready` high completes it. Each access completes exactly once.
- R8: A `start` pulse while `busy` is high is ignored.
- R9: After reset, `busy`, `done`, `fail`, `bus_req` and `img_rd` are low.
- R10: At the end of a run, `busy` falls and `done` rises together. `done` stays high until the next accepted `start`. Image reads and bus requests occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, taken only when idle |
| img_rd | output | 1 | Image memory read enable |
| img_addr | output | IMG_AW | Image memory word address |
| img_data | input | 32 | Image word, valid one cycle after `img_rd` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | REG_AW | Device register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Completes the pending access |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | REG_AW | Register address of the first mismatch |
| fail_vec | output | 32 | Mismatch bits of the first failure |

## Verification
The merge is tried with five single-word vectors. A full mask tells a true merge apart from keeping the old word, and an empty mask does the opposite. Nibble and byte masks catch swapped operands or an inverted mask. A two-block image whose stimulus block 1 overwrites a register that checking block 0 inspects can only pass if blocks alternate. Its multi-word and multi-sequence layout exposes errors in pointer arithmetic and length. A failing image has two mismatches and a masked-off difference. It separates first-failure capture from last-failure capture and from comparison that ignores the mask. The empty-block, zero-count, slow-ready and busy-restart cases each target one specific control path.

// File: rtl/imgseq_pkg.sv
package imgseq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [4:0] {
        S_IDLE,
        S_HDR_RD,  S_HDR_LD,
        S_BLK_RD,  S_BLK_LD,
        S_BEND_RD, S_BEND_LD,
        S_NSEQ_RD, S_NSEQ_LD,
        S_SEQ_RD,  S_SEQ_LD,
        S_SEND_RD, S_SEND_LD,
        S_REG_RD,  S_REG_LD,
        S_VAL_RD,  S_VAL_LD,
        S_MSK_RD,  S_MSK_LD,
        S_BUS_RD,  S_BUS_WR,
        S_STEP_WORD, S_STEP_SEQ, S_STEP_BLK
    } seq_state_e;

endpackage

// File: rtl/imgseq_merge.sv
module imgseq_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    output logic [W-1:0] merged
);
    // Masked bits take the stimulus value, the others keep their state.
    assign merged = (~msk & cur) | (msk & val);
endmodule

// File: rtl/imgseq_cmp.sv
module imgseq_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] rd,
    input  logic [W-1:0] expect_w,
    input  logic [W-1:0] msk,
    output logic [W-1:0] mism
);
    assign mism = msk & (rd ^ expect_w);
endmodule

// File: rtl/imgseq_faillatch.sv
module imgseq_faillatch #(
    parameter int AW = 16,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          check,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  mism,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [W-1:0]  fail_vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_vec  <= '0;
        end else if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_vec  <= '0;
        end else if (check && (|mism) && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_vec  <= mism;
        end
    end
endmodule

// File: rtl/imgseq_engine.sv
module imgseq_engine
    import imgseq_pkg::*;
#(
    parameter int IMG_AW   = 10,
    parameter int REG_AW   = 16,
    parameter int CNT_W    = 8,
    parameter int IN_BASE  = 0,
    parameter int OUT_BASE = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                img_rd,
    output logic [IMG_AW-1:0]   img_addr,
    input  logic [WORD_W-1:0]   img_data,
    output logic                bus_req,
    output logic                bus_we,
    output logic [REG_AW-1:0]   bus_addr,
    output logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   bus_rdata,
    input  logic                bus_ready,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [REG_AW-1:0]   fail_addr,
    output logic [WORD_W-1:0]   fail_vec
);
    localparam logic [IMG_AW-1:0] IN_B  = IMG_AW'(IN_BASE);
    localparam logic [IMG_AW-1:0] OUT_B = IMG_AW'(OUT_BASE);
    localparam int FIELD_MAX = (REG_AW > IMG_AW) ?
                               ((REG_AW > CNT_W) ? REG_AW : CNT_W) :
                               ((IMG_AW > CNT_W) ? IMG_AW : CNT_W);

    seq_state_e state, nxt;

    logic                phase_out;
    logic [CNT_W-1:0]    nblk, bidx, nseq, sidx;
    logic [IMG_AW-1:0]   blk_ptr, blk_end, seq_ptr, seq_end, len, widx;
    logic [REG_AW-1:0]   reg_base;
    logic [WORD_W-1:0]   val_q, msk_q, cur_q;

    logic [CNT_W-1:0]    bidx_nx, sidx_nx;
    logic [IMG_AW-1:0]   widx_nx, span, len_calc, part_base;
    logic                last_seq, finish, accept, chk_now;
    logic [WORD_W-1:0]   merged, mism;
    logic                span_unused_lsb, img_unused_hi;

    assign bidx_nx   = bidx + 1'b1;
    assign sidx_nx   = sidx + 1'b1;
    assign widx_nx   = widx + 1'b1;
    assign last_seq  = (sidx_nx == nseq);
    assign span      = seq_end - seq_ptr - 1'b1;
    assign len_calc  = {1'b0, span[IMG_AW-1:1]};
    assign span_unused_lsb = span[0];
    assign img_unused_hi   = ^img_data[WORD_W-1:FIELD_MAX];
    assign part_base = phase_out ? OUT_B : IN_B;
    assign accept    = (state == S_IDLE) && start;
    assign finish    = ((state == S_HDR_LD) && (img_data[CNT_W-1:0] == '0)) ||
                       ((state == S_STEP_BLK) && phase_out && (bidx_nx == nblk));
    assign chk_now   = (state == S_BUS_RD) && bus_ready && phase_out;
    assign busy      = (state != S_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start) nxt = S_HDR_RD;
            S_HDR_RD:    nxt = S_HDR_LD;
            S_HDR_LD:    nxt = (img_data[CNT_W-1:0] == '0) ? S_IDLE : S_BLK_RD;
            S_BLK_RD:    nxt = S_BLK_LD;
            S_BLK_LD:    nxt = S_BEND_RD;
            S_BEND_RD:   nxt = S_BEND_LD;
            S_BEND_LD:   nxt = S_NSEQ_RD;
            S_NSEQ_RD:   nxt = S_NSEQ_LD;
            S_NSEQ_LD:   nxt = (img_data[CNT_W-1:0] == '0) ? S_STEP_BLK : S_SEQ_RD;
            S_SEQ_RD:    nxt = S_SEQ_LD;
            S_SEQ_LD:    nxt = S_SEND_RD;
            S_SEND_RD:   nxt = S_SEND_LD;
            S_SEND_LD:   nxt = S_REG_RD;
            S_REG_RD:    nxt = S_REG_LD;
            S_REG_LD:    nxt = (len_calc == '0) ? S_STEP_SEQ : S_VAL_RD;
            S_VAL_RD:    nxt = S_VAL_LD;
            S_VAL_LD:    nxt = S_MSK_RD;
            S_MSK_RD:    nxt = S_MSK_LD;
            S_MSK_LD:    nxt = S_BUS_RD;
            S_BUS_RD:    if (bus_ready) nxt = phase_out ? S_STEP_WORD : S_BUS_WR;
            S_BUS_WR:    if (bus_ready) nxt = S_STEP_WORD;
            S_STEP_WORD: nxt = (widx_nx == len) ? S_STEP_SEQ : S_VAL_RD;
            S_STEP_SEQ:  nxt = last_seq ? S_STEP_BLK : S_SEQ_RD;
            S_STEP_BLK:  nxt = finish ? S_IDLE : S_BLK_RD;
            default:     nxt = S_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        img_rd   = 1'b0;
        img_addr = '0;
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        unique case (state)
            S_HDR_RD:  begin img_rd = 1'b1; img_addr = IN_B; end
            S_BLK_RD:  begin img_rd = 1'b1; img_addr = part_base + IMG_AW'(bidx) + 1'b1; end
            S_BEND_RD: begin img_rd = 1'b1; img_addr = part_base + IMG_AW'(bidx) + 2'd2; end
            S_NSEQ_RD: begin img_rd = 1'b1; img_addr = blk_ptr; end
            S_SEQ_RD:  begin img_rd = 1'b1; img_addr = blk_ptr + IMG_AW'(sidx) + 1'b1; end
            S_SEND_RD: begin img_rd = !last_seq; img_addr = blk_ptr + IMG_AW'(sidx) + 2'd2; end
            S_REG_RD:  begin img_rd = 1'b1; img_addr = seq_ptr; end
            S_VAL_RD:  begin img_rd = 1'b1; img_addr = seq_ptr + widx + 1'b1; end
            S_MSK_RD:  begin img_rd = 1'b1; img_addr = seq_ptr + len + widx + 1'b1; end
            S_BUS_RD:  bus_req = 1'b1;
            S_BUS_WR:  begin bus_req = 1'b1; bus_we = 1'b1; end
            default:   ;
        endcase
    end

    assign bus_addr  = reg_base + REG_AW'(widx);
    assign bus_wdata = (state == S_BUS_WR) ? merged : '0;

    // Walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_out <= 1'b0;
            nblk <= '0; bidx <= '0; nseq <= '0; sidx <= '0;
            blk_ptr <= '0; blk_end <= '0; seq_ptr <= '0; seq_end <= '0;
            len <= '0; widx <= '0; reg_base <= '0;
            val_q <= '0; msk_q <= '0; cur_q <= '0;
            done <= 1'b0;
        end else begin
            if (accept) begin
                phase_out <= 1'b0;
                bidx      <= '0;
                done      <= 1'b0;
            end
            if (finish) done <= 1'b1;
            unique case (state)
                S_HDR_LD:    nblk    <= img_data[CNT_W-1:0];
                S_BLK_LD:    blk_ptr <= img_data[IMG_AW-1:0];
                S_BEND_LD:   blk_end <= img_data[IMG_AW-1:0];
                S_NSEQ_LD:   begin nseq <= img_data[CNT_W-1:0]; sidx <= '0; end
                S_SEQ_LD:    seq_ptr <= img_data[IMG_AW-1:0];
                S_SEND_LD:   seq_end <= last_seq ? blk_end : img_data[IMG_AW-1:0];
                S_REG_LD:    begin reg_base <= img_data[REG_AW-1:0]; len <= len_calc; widx <= '0; end
                S_VAL_LD:    val_q <= img_data;
                S_MSK_LD:    msk_q <= img_data;
                S_BUS_RD:    if (bus_ready) cur_q <= bus_rdata;
                S_STEP_WORD: widx <= widx_nx;
                S_STEP_SEQ:  sidx <= sidx_nx;
                S_STEP_BLK:  begin
                    phase_out <= !phase_out;
                    if (phase_out) bidx <= bidx_nx;
                end
                default: ;
            endcase
        end
    end

    imgseq_merge #(.W(WORD_W)) u_merge (
        .cur(cur_q), .val(val_q), .msk(msk_q), .merged(merged)
    );

    imgseq_cmp #(.W(WORD_W)) u_cmp (
        .rd(bus_rdata), .expect_w(val_q), .msk(msk_q), .mism(mism)
    );

    imgseq_faillatch #(.AW(REG_AW), .W(WORD_W)) u_fail (
        .clk(clk), .rst_n(rst_n), .clear(accept), .check(chk_now),
        .addr(bus_addr), .mism(mism),
        .fail(fail), .fail_addr(fail_addr), .fail_vec(fail_vec)
    );
endmodule

// File: rtl/imgseq_engine_chk.sv
module imgseq_engine_chk #(
    parameter int REG_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [REG_AW-1:0] fail_addr,
    input logic [31:0]       fail_vec,
    input logic              bus_req,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready,
    input logic              img_rd
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> fail); // R6

    AST_FAIL_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> ($stable(fail_addr) && $stable(fail_vec))); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!img_rd && !bus_req)); // R10
endmodule

bind imgseq_engine imgseq_engine_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_vec(fail_vec),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .img_rd(img_rd)
);

// File: tb/imgseq_engine_bench.sv
module imgseq_engine_bench;
    localparam int IMG_AW = 10;
    localparam int REG_AW = 16;
    localparam int OB     = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic img_rd;
    logic [IMG_AW-1:0] img_addr;
    logic [31:0] img_data = '0;
    logic bus_req, bus_we, bus_ready = 1'b0;
    logic [REG_AW-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic busy, done, fail;
    logic [REG_AW-1:0] fail_addr;
    logic [31:0] fail_vec;

    logic [31:0] mem [0:255];
    logic [31:0] regs [0:63];
    int nrd = 0, nwr = 0, rbw_err = 0, ready_delay = 0, wcnt = 0;
    logic last_rd_ok = 1'b0;
    logic [REG_AW-1:0] last_rd_addr = '0;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    imgseq_engine #(.IMG_AW(IMG_AW), .REG_AW(REG_AW), .OUT_BASE(OB)) u_imgseq_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_rd(img_rd), .img_addr(img_addr), .img_data(img_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr), .fail_vec(fail_vec)
    );

    // Image memory: one cycle read latency
    always @(posedge clk) if (img_rd) img_data <= mem[img_addr[7:0]];

    // Device register model
    assign bus_rdata = regs[bus_addr[5:0]];
    always @(posedge clk) begin
        if (bus_req && bus_ready) begin
            if (bus_we) begin
                nwr++;
                if (!(last_rd_ok && last_rd_addr == bus_addr)) rbw_err++;
                regs[bus_addr[5:0]] <= bus_wdata;
                last_rd_ok <= 1'b0;
            end else begin
                nrd++;
                last_rd_ok   <= 1'b1;
                last_rd_addr <= bus_addr;
            end
        end
    end
    always @(negedge clk) begin
        if (!bus_req || bus_ready) begin
            bus_ready <= 1'b0;
            wcnt <= 0;
        end else if (wcnt >= ready_delay) bus_ready <= 1'b1;
        else wcnt <= wcnt + 1;
    end

    // {current, value, mask, expected}
    localparam logic [127:0] VEC [0:4] = '{
        {32'hFFFF0000, 32'h12345678, 32'hFFFFFFFF, 32'h12345678},
        {32'hA5A5A5A5, 32'h00000000, 32'h00000000, 32'hA5A5A5A5},
        {32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0F0F0F0F},
        {32'hDEADBEEF, 32'h00000000, 32'hFF00FF00, 32'h00AD00EF},
        {32'h13572468, 32'hECA8DB97, 32'hF0F0F0F0, 32'hE3A7D498}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    // One block, one sequence, one word, laid out at base
    task automatic build_single(input int base, input int ra, input logic [31:0] v, input logic [31:0] m);
        mem[base]   = 1;        mem[base+1] = base + 3; mem[base+2] = base + 8;
        mem[base+3] = 1;        mem[base+4] = base + 5;
        mem[base+5] = ra;       mem[base+6] = v;        mem[base+7] = m;
    endtask

    task automatic build_multi();
        clear_mem();
        mem[0] = 2; mem[1] = 4; mem[2] = 17; mem[3] = 26;
        mem[4] = 2; mem[5] = 7; mem[6] = 14;
        mem[7] = 10; mem[8] = 32'h11110000; mem[9] = 32'h22220001; mem[10] = 32'h33330002;
        mem[11] = '1; mem[12] = '1; mem[13] = '1;
        mem[14] = 20; mem[15] = 32'h0000AAAA; mem[16] = '1;
        mem[17] = 2; mem[18] = 20; mem[19] = 23;
        mem[20] = 20; mem[21] = 32'h0000BBBB; mem[22] = '1;
        mem[23] = 30; mem[24] = 32'h12349999; mem[25] = 32'h0000FFFF;
        mem[OB] = 2; mem[OB+1] = 132; mem[OB+2] = 145; mem[OB+3] = 154;
        mem[132] = 2; mem[133] = 135; mem[134] = 142;
        mem[135] = 10; mem[136] = 32'h11110000; mem[137] = 32'h22220001; mem[138] = 32'h33330002;
        mem[139] = '1; mem[140] = '1; mem[141] = '1;
        mem[142] = 20; mem[143] = 32'h0000AAAA; mem[144] = '1;
        mem[145] = 2; mem[146] = 148; mem[147] = 151;
        mem[148] = 20; mem[149] = 32'h0000BBBB; mem[150] = '1;
        mem[151] = 30; mem[152] = 32'hDDDD9999; mem[153] = '1;
        regs[10] = '0; regs[11] = '0; regs[12] = '0; regs[20] = '0; regs[30] = 32'hDDDD1111;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_image();
        pulse_start();
        while (!done) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        int r0, w0, e0;
        for (int i = 0; i < 64; i++) regs[i] = '0;
        clear_mem();
        repeat (5) @(negedge clk);
        // R9: reset state
        check(!busy && !done && !fail, "R9 status after reset", {29'd0, busy, done, fail}, 32'd0);
        check(!bus_req && !img_rd, "R9 requests after reset", {30'd0, bus_req, img_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of single-word merge vectors (R4, R5)
        for (int i = 0; i < 5; i++) begin
            clear_mem();
            build_single(0, 4, VEC[i][95:64], VEC[i][63:32]);
            build_single(OB, 4, VEC[i][31:0], 32'hFFFFFFFF);
            regs[4] = VEC[i][127:96];
            ready_delay = i % 3;
            r0 = nrd; w0 = nwr; e0 = rbw_err;
            run_image();
            check(regs[4] == VEC[i][31:0], "R4 merged register", regs[4], VEC[i][31:0]);
            check(!fail, "R5 check of merged word", {31'd0, fail}, 32'd0);
            check(nrd - r0 == 2, "R4 read count", nrd - r0, 32'd2);
            check(nwr - w0 == 1, "R7 write count", nwr - w0, 32'd1);
            check(rbw_err == e0, "R4 read before write", rbw_err - e0, 32'd0);
        end

        // R2, R3: two blocks, multi-word and multi-sequence, alternating order
        build_multi();
        ready_delay = 1;
        r0 = nrd; w0 = nwr;
        pulse_start();
        @(negedge clk);
        check(busy && !done, "R1 busy during run", {30'd0, busy, done}, 32'd2);
        while (!done) @(negedge clk);
        check(!fail, "R2 alternating order passes", {31'd0, fail}, 32'd0);
        check(regs[11] == 32'h22220001, "R3 consecutive words", regs[11], 32'h22220001);
        check(regs[12] == 32'h33330002, "R3 length from pointers", regs[12], 32'h33330002);
        check(regs[20] == 32'h0000BBBB, "R2 later block wins", regs[20], 32'h0000BBBB);
        check(regs[30] == 32'hDDDD9999, "R4 half mask", regs[30], 32'hDDDD9999);
        check(nwr - w0 == 6, "R3 stimulus writes", nwr - w0, 32'd6);
        check(nrd - r0 == 12, "R3 total reads", nrd - r0, 32'd12);
        check(!busy && done, "R10 completion", {30'd0, busy, done}, 32'd1);

        // R5, R6: empty stimulus block, two mismatches, masked difference
        clear_mem();
        mem[0] = 1; mem[1] = 3; mem[2] = 4; mem[3] = 0;
        mem[OB] = 1; mem[OB+1] = 131; mem[OB+2] = 144;
        mem[131] = 2; mem[132] = 134; mem[133] = 139;
        mem[134] = 40; mem[135] = 32'h000000F0; mem[136] = 32'h12345679;
        mem[137] = 32'h000000F0; mem[138] = 32'hFFFFFFF0;
        mem[139] = 50; mem[140] = 32'hAAAA0001; mem[141] = 32'hFFFFFFFF;
        mem[142] = 32'h00000003; mem[143] = 32'hFFFFFFFF;
        regs[40] = 32'h000000FF; regs[41] = 32'h12345678;
        regs[50] = 32'hAAAA0000; regs[51] = 32'h00000000;
        ready_delay = 3;
        r0 = nrd; w0 = nwr;
        run_image();
        check(fail, "R6 fail flag", {31'd0, fail}, 32'd1);
        check(fail_addr == 50, "R6 first failing address", {16'd0, fail_addr}, 32'd50);
        check(fail_vec == 32'h00000001, "R6 first mismatch vector", fail_vec, 32'h00000001);
        check(nrd - r0 == 4, "R6 run continues after failure", nrd - r0, 32'd4);
        check(nwr == w0, "R5 no writes in checking", nwr - w0, 32'd0);
        check(regs[40] == 32'h000000FF, "R5 register untouched", regs[40], 32'h000000FF);

        // R1: zero blocks, and R6 clear on new start
        clear_mem();
        r0 = nrd; w0 = nwr;
        run_image();
        check(!fail, "R6 start clears fail", {31'd0, fail}, 32'd0);
        check(nrd == r0 && nwr == w0, "R1 zero blocks no access", (nrd - r0) + (nwr - w0), 32'd0);
        check(done && !busy, "R1 zero blocks completes", {30'd0, busy, done}, 32'd1);

        // R8: start while busy ignored
        build_multi();
        ready_delay = 0;
        w0 = nwr;
        pulse_start();
        repeat (30) @(negedge clk);
        check(busy, "R8 busy before second start", {31'd0, busy}, 32'd1);
        pulse_start();
        while (!done) @(negedge clk);
        repeat (20) @(negedge clk);
        check(!busy && done, "R8 no restart", {30'd0, busy, done}, 32'd1);
        check(nwr - w0 == 6, "R8 single run of writes", nwr - w0, 32'd6);

        summary();
        $finish;
    end
endmodule